// File: doc/BRIEF.md
# Event Statistics Counter Unit

This block gives software a bank of event counters on an APB register port. Each counter has a configuration word with three parts: an event code, a source index that picks one of up to sixteen processors or bus masters, and an enable bit. While the counter is enabled, it adds one on every clock in which the chosen event line is high. A free-running timestamp register sits next to the counters. Software can preset any counter value, maximum register or the timestamp, and can read them back.

Event lines arrive on one flat vector. Each source has 128 event codes. Codes are grouped: processor events, internal-bus utilisation, debug-bus monitor events, sixteen external lines and a trace-bus monitor group. A build parameter removes each optional group; a code in a removed group never counts. When maximum-count support is built in, a counter can run in run-length mode. In that mode it measures each unbroken high run of its event and keeps the longest run seen in a per-counter maximum register.

APB access has no wait states. Every transfer completes in its access phase and the block never applies back-pressure. Read data is combinational from the addressed register.

Top module: `evstat_unit`

## Requirements
- R1: After reset, every counter value, maximum register and configuration field is zero, and the timestamp starts from zero.
- R2: Word registers are decoded from paddr[8:7] and paddr[6:2]. Counter i's value is at 0x000+4i, its configuration at 0x080+4i and its maximum at 0x100+4i. The timestamp is at 0x180. Value, maximum and timestamp registers read back what was last written, adjusted by any counting since.
- R3: The configuration word has enable at bit 0, run-length mode at bit 1, level option at bit 2, event code at bits 10:4 and source index at bits 15:12. These fields read back as written. While enable is 0 the counter value does not change except by a write, so writing all zeros stops the counter.
- R4: An enabled counter in normal mode adds 1 on each clock where ev_in[source*128 + code] is high. Lines of any other source or code have no effect. The value wraps from 0xFFFFFFFF to 0.
- R5: In run-length mode an enabled counter adds 1 on each high cycle. On the first clock after its event goes low, it copies the count into the maximum register if the count is larger, and it restarts from 0. Outside a write or such a capture, the maximum register never changes.
- R6: The timestamp adds 1 on every clock. A write to the timestamp in the same cycle wins.
- R7: A read of counter 0's configuration word also shows the number of counters minus one in bits 20:16. It shows flags for maximum support (bit 23), internal-bus events (24), debug-bus events (25), external events (26) and trace-bus events (27).
- R8: Reads of counter slots at or above the implemented count, and of timestamp-region words other than 0x180, return zero. Writes to them change no register.
- R9: Codes 0x17 and 0x18 are internal-bus events, 0x40–0x5F debug-bus events, 0x60–0x6F external lines and 0x70–0x7F trace-bus events. A code whose group is not built in never causes counting. In the default build the trace-bus group is absent.
- R10: A write to a counter value in the same cycle as an increment wins over the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 9 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| ev_in | input | NSRC*128 (2048) | Event lines, bit source*128+code |

## Verification
A bad configuration field shows up at once when software reads it back. It also shows up at the next value read, which has counted the wrong line or counted while it should have held. A wrong run-length state only shows after a run ends, when the maximum register is read. Errors in address decode show through aliasing: a write to an unimplemented slot or another region changes a register that is then read back. The bench catches these by comparing every read against a cycle-accurate model.

// File: rtl/evstat_pkg.sv
package evstat_pkg;

  localparam int WORD_W = 32;
  localparam int ADDR_W = 9;
  localparam int CODE_W = 7;
  localparam int CODES  = 1 << CODE_W;
  localparam int SRC_W  = 4;
  localparam int IDX_W  = 5;

  // configuration word field positions
  localparam int F_EN    = 0;
  localparam int F_MAXD  = 1;
  localparam int F_LVL   = 2;
  localparam int F_CODE  = 4;
  localparam int F_SRC   = 12;
  localparam int F_NCNT  = 16;
  localparam int F_HMAX  = 23;
  localparam int F_HIBUS = 24;
  localparam int F_HDBG  = 25;
  localparam int F_HEXT  = 26;
  localparam int F_HTRC  = 27;

  typedef enum logic [1:0] {
    SP_VALUE = 2'd0,
    SP_CTRL  = 2'd1,
    SP_MAX   = 2'd2,
    SP_TIME  = 2'd3
  } space_e;

  typedef struct packed {
    logic [SRC_W-1:0]  src;
    logic [CODE_W-1:0] code;
    logic              lvl;
    logic              maxd;
    logic              en;
  } cnt_cfg_t;

  function automatic logic [WORD_W-1:0] cfg_word(cnt_cfg_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[F_EN]               = c.en;
    w[F_MAXD]             = c.maxd;
    w[F_LVL]              = c.lvl;
    w[F_CODE +: CODE_W]   = c.code;
    w[F_SRC +: SRC_W]     = c.src;
    return w;
  endfunction

  function automatic logic code_present(logic [CODE_W-1:0] c, logic ibus,
                                        logic dbg, logic ext, logic trc);
    if (c == 7'h17 || c == 7'h18) return ibus;
    if (c[6:5] == 2'b10)          return dbg;
    if (c[6:4] == 3'b110)         return ext;
    if (c[6:4] == 3'b111)         return trc;
    return 1'b1;
  endfunction

endpackage

// File: rtl/evstat_evsel.sv
module evstat_evsel
  import evstat_pkg::*;
#(
  parameter int NSRC     = 16,
  parameter bit HAS_IBUS = 1'b1,
  parameter bit HAS_DBG  = 1'b1,
  parameter bit HAS_EXT  = 1'b1,
  parameter bit HAS_TRC  = 1'b0
) (
  input  logic [NSRC*CODES-1:0] ev_in,
  input  logic [SRC_W-1:0]      src,
  input  logic [CODE_W-1:0]     code,
  output logic                  hit
);
  localparam int FLAT  = NSRC * CODES;
  localparam int SEL_W = $clog2(FLAT);

  logic [SEL_W-1:0] sel;
  logic             src_ok;
  logic             grp_ok;

  always_comb begin
    sel    = SEL_W'({src, code});
    src_ok = int'(src) < NSRC;
    grp_ok = code_present(code, HAS_IBUS, HAS_DBG, HAS_EXT, HAS_TRC);
    hit    = src_ok && grp_ok && ev_in[sel];
  end
endmodule

// File: rtl/evstat_counter.sv
module evstat_counter
  import evstat_pkg::*;
#(
  parameter bit HAS_MAX = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              wr_cfg,
  input  logic              wr_val,
  input  logic              wr_max,
  input  logic [WORD_W-1:0] wdata,
  output cnt_cfg_t          cfg,
  output logic [WORD_W-1:0] val,
  output logic [WORD_W-1:0] maxv
);
  logic hit_q;
  logic run_end;

  assign run_end = cfg.en && cfg.maxd && hit_q && !hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_cfg) begin
      cfg.en   <= wdata[F_EN];
      cfg.maxd <= HAS_MAX && wdata[F_MAXD];
      cfg.lvl  <= HAS_MAX && wdata[F_LVL];
      cfg.code <= wdata[F_CODE +: CODE_W];
      cfg.src  <= wdata[F_SRC +: SRC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val <= '0;
    end else if (wr_val) begin
      val <= wdata;
    end else if (run_end) begin
      val <= '0;
    end else if (cfg.en && hit) begin
      val <= val + 1'b1;
    end
  end

  generate
    if (HAS_MAX) begin : g_max
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          maxv <= '0;
        end else if (wr_max) begin
          maxv <= wdata;
        end else if (run_end && (val > maxv)) begin
          maxv <= val;
        end
      end
    end else begin : g_nomax
      logic unused_wmax;
      assign unused_wmax = wr_max;
      assign maxv = '0;
    end
  endgenerate
endmodule

// File: rtl/evstat_regif.sv
module evstat_regif
  import evstat_pkg::*;
#(
  parameter int NCNT = 4
) (
  input  logic                         psel,
  input  logic                         penable,
  input  logic                         pwrite,
  input  logic [ADDR_W-1:0]            paddr,
  input  logic [NCNT-1:0][WORD_W-1:0]  val_a,
  input  logic [NCNT-1:0][WORD_W-1:0]  ctl_a,
  input  logic [NCNT-1:0][WORD_W-1:0]  max_a,
  input  logic [WORD_W-1:0]            ts_q,
  output logic [NCNT-1:0]              wr_val,
  output logic [NCNT-1:0]              wr_cfg,
  output logic [NCNT-1:0]              wr_max,
  output logic                         ts_we,
  output logic [WORD_W-1:0]            prdata
);
  space_e           space;
  logic [IDX_W-1:0] idx;
  logic             wr_acc;
  logic             unused_lsb;

  assign space      = space_e'(paddr[ADDR_W-1 -: 2]);
  assign idx        = paddr[2 +: IDX_W];
  assign wr_acc     = psel && penable && pwrite;
  assign unused_lsb = ^paddr[1:0];
  assign ts_we      = wr_acc && (space == SP_TIME) && (idx == '0);

  generate
    for (genvar i = 0; i < NCNT; i++) begin : g_dec
      logic hit_idx;
      assign hit_idx   = wr_acc && (idx == IDX_W'(i));
      assign wr_val[i] = hit_idx && (space == SP_VALUE);
      assign wr_cfg[i] = hit_idx && (space == SP_CTRL);
      assign wr_max[i] = hit_idx && (space == SP_MAX);
    end
  endgenerate

  always_comb begin
    prdata = '0;
    case (space)
      SP_VALUE: for (int i = 0; i < NCNT; i++) if (idx == IDX_W'(i)) prdata = val_a[i];
      SP_CTRL:  for (int i = 0; i < NCNT; i++) if (idx == IDX_W'(i)) prdata = ctl_a[i];
      SP_MAX:   for (int i = 0; i < NCNT; i++) if (idx == IDX_W'(i)) prdata = max_a[i];
      default:  if (idx == '0) prdata = ts_q;
    endcase
  end
endmodule

// File: rtl/evstat_unit.sv
module evstat_unit
  import evstat_pkg::*;
#(
  parameter int NCNT      = 4,
  parameter int NSRC      = 16,
  parameter bit HAS_MAX   = 1'b1,
  parameter bit HAS_IBUS  = 1'b1,
  parameter bit HAS_DBG   = 1'b1,
  parameter bit HAS_EXT   = 1'b1,
  parameter bit HAS_TRACE = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   psel,
  input  logic                   penable,
  input  logic                   pwrite,
  input  logic [ADDR_W-1:0]      paddr,
  input  logic [WORD_W-1:0]      pwdata,
  output logic [WORD_W-1:0]      prdata,
  input  logic [NSRC*CODES-1:0]  ev_in
);
  localparam logic [WORD_W-1:0] CAP_WORD =
      (WORD_W'(NCNT - 1)   << F_NCNT)  |
      (WORD_W'(HAS_MAX)    << F_HMAX)  |
      (WORD_W'(HAS_IBUS)   << F_HIBUS) |
      (WORD_W'(HAS_DBG)    << F_HDBG)  |
      (WORD_W'(HAS_EXT)    << F_HEXT)  |
      (WORD_W'(HAS_TRACE)  << F_HTRC);

  cnt_cfg_t [NCNT-1:0]          cfg_a;
  logic [NCNT-1:0][WORD_W-1:0]  val_a;
  logic [NCNT-1:0][WORD_W-1:0]  max_a;
  logic [NCNT-1:0][WORD_W-1:0]  ctl_w;
  logic [NCNT-1:0]              wr_val, wr_cfg, wr_max;
  logic [NCNT-1:0]              hit_v, en_v, maxd_v;
  logic [NCNT-1:0][CODE_W-1:0]  code_v;
  logic                         ts_we;
  logic [WORD_W-1:0]            ts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ts_q <= '0;
    else if (ts_we) ts_q <= pwdata;
    else            ts_q <= ts_q + 1'b1;
  end

  evstat_regif #(.NCNT(NCNT)) u_regif (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .val_a   (val_a),
    .ctl_a   (ctl_w),
    .max_a   (max_a),
    .ts_q    (ts_q),
    .wr_val  (wr_val),
    .wr_cfg  (wr_cfg),
    .wr_max  (wr_max),
    .ts_we   (ts_we),
    .prdata  (prdata)
  );

  generate
    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
      evstat_evsel #(
        .NSRC(NSRC), .HAS_IBUS(HAS_IBUS), .HAS_DBG(HAS_DBG),
        .HAS_EXT(HAS_EXT), .HAS_TRC(HAS_TRACE)
      ) u_sel (
        .ev_in (ev_in),
        .src   (cfg_a[i].src),
        .code  (cfg_a[i].code),
        .hit   (hit_v[i])
      );

      evstat_counter #(.HAS_MAX(HAS_MAX)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit_v[i]),
        .wr_cfg (wr_cfg[i]),
        .wr_val (wr_val[i]),
        .wr_max (wr_max[i]),
        .wdata  (pwdata),
        .cfg    (cfg_a[i]),
        .val    (val_a[i]),
        .maxv   (max_a[i])
      );

      assign ctl_w[i]  = cfg_word(cfg_a[i]) | ((i == 0) ? CAP_WORD : '0);
      assign en_v[i]   = cfg_a[i].en;
      assign maxd_v[i] = cfg_a[i].maxd;
      assign code_v[i] = cfg_a[i].code;
    end
  endgenerate
endmodule

// File: rtl/evstat_unit_chk.sv
module evstat_unit_chk
  import evstat_pkg::*;
#(
  parameter int NCNT      = 4,
  parameter bit HAS_TRACE = 1'b0
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        psel,
  input logic                        pwrite,
  input logic [ADDR_W-1:0]           paddr,
  input logic [WORD_W-1:0]           prdata,
  input logic                        ts_we,
  input logic [WORD_W-1:0]           ts_q,
  input logic [NCNT-1:0]             en_v,
  input logic [NCNT-1:0]             maxd_v,
  input logic [NCNT-1:0]             hit_v,
  input logic [NCNT-1:0]             wr_val,
  input logic [NCNT-1:0]             wr_max,
  input logic [NCNT-1:0][CODE_W-1:0] code_v,
  input logic [NCNT-1:0][WORD_W-1:0] val_a,
  input logic [NCNT-1:0][WORD_W-1:0] max_a
);
  p_ts_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ts_we |=> ts_q == $past(ts_q) + 32'd1);

  p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_v[0] && !wr_val[0]) |=> $stable(val_a[0]));

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_v[0] && !maxd_v[0] && hit_v[0] && !wr_val[0]) |=> val_a[0] == $past(val_a[0]) + 32'd1);

  p_max_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_max[0] |=> max_a[0] >= $past(max_a[0]));

  p_unimpl_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && (paddr[8:7] != 2'b11) && (int'(paddr[6:2]) >= NCNT)) |-> prdata == '0);

  generate
    for (genvar i = 0; i < NCNT; i++) begin : g_grp
      if (!HAS_TRACE) begin : g_notrc
        p_absent_group_r9: assert property (@(posedge clk) disable iff (!rst_n)
          (code_v[i][6:4] == 3'b111) |-> !hit_v[i]);
      end
    end
  endgenerate
endmodule

bind evstat_unit evstat_unit_chk #(.NCNT(NCNT), .HAS_TRACE(HAS_TRACE)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .psel   (psel),
  .pwrite (pwrite),
  .paddr  (paddr),
  .prdata (prdata),
  .ts_we  (ts_we),
  .ts_q   (ts_q),
  .en_v   (en_v),
  .maxd_v (maxd_v),
  .hit_v  (hit_v),
  .wr_val (wr_val),
  .wr_max (wr_max),
  .code_v (code_v),
  .val_a  (val_a),
  .max_a  (max_a)
);

// File: tb/evstat_unit_test.sv
module evstat_unit_test;
  import evstat_pkg::*;

  localparam int NCNT = 4;
  localparam int NSRC = 16;
  localparam int FLAT = NSRC * 128;
  localparam logic [31:0] EXP_CAP = 32'h0783_0000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [8:0]      paddr = '0;
  logic [31:0]     pwdata = '0;
  logic [31:0]     prdata;
  logic [FLAT-1:0] ev_in = '0;
  logic            ev_rand = 1'b0;
  int              n_run = 0, n_fail = 0;
  bit              done = 0;

  always #10 clk = ~clk;

  evstat_unit uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .ev_in(ev_in)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_val [NCNT];
  logic [31:0] m_max [NCNT];
  logic        m_en [NCNT], m_maxd [NCNT], m_lvl [NCNT], m_prev [NCNT];
  logic [6:0]  m_code [NCNT];
  logic [3:0]  m_src [NCNT];
  logic [31:0] m_ts;

  function automatic bit m_present(logic [6:0] c);
    if (c == 7'h17 || c == 7'h18) return 1'b1;
    if (c >= 7'h70) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic m_hit(int i);
    return m_present(m_code[i]) && ev_in[int'(m_src[i]) * 128 + int'(m_code[i])];
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    logic wr;
    int   sp, ix;
    logic h;
    if (!rst_n) begin
      m_ts <= '0;
      for (int i = 0; i < NCNT; i++) begin
        m_val[i] <= '0; m_max[i] <= '0; m_en[i] <= 0; m_maxd[i] <= 0;
        m_lvl[i] <= 0; m_prev[i] <= 0; m_code[i] <= '0; m_src[i] <= '0;
      end
    end else begin
      wr = psel && penable && pwrite;
      sp = int'(paddr[8:7]);
      ix = int'(paddr[6:2]);
      m_ts <= (wr && sp == 3 && ix == 0) ? pwdata : m_ts + 32'd1;
      for (int i = 0; i < NCNT; i++) begin
        h = m_hit(i);
        m_prev[i] <= h;
        if (wr && sp == 0 && ix == i) m_val[i] <= pwdata;
        else if (m_en[i]) begin
          if (m_maxd[i] && m_prev[i] && !h) m_val[i] <= '0;
          else if (h) m_val[i] <= m_val[i] + 32'd1;
        end
        if (wr && sp == 2 && ix == i) m_max[i] <= pwdata;
        else if (m_en[i] && m_maxd[i] && m_prev[i] && !h && m_val[i] > m_max[i])
          m_max[i] <= m_val[i];
        if (wr && sp == 1 && ix == i) begin
          m_en[i] <= pwdata[0]; m_maxd[i] <= pwdata[1]; m_lvl[i] <= pwdata[2];
          m_code[i] <= pwdata[10:4]; m_src[i] <= pwdata[15:12];
        end
      end
    end
  end

  function automatic logic [31:0] m_read(logic [8:0] a);
    int sp = int'(a[8:7]);
    int ix = int'(a[6:2]);
    logic [31:0] w;
    if (sp == 3) return (ix == 0) ? m_ts : 32'd0;
    if (ix >= NCNT) return 32'd0;
    if (sp == 0) return m_val[ix];
    if (sp == 2) return m_max[ix];
    w = '0;
    w[0] = m_en[ix]; w[1] = m_maxd[ix]; w[2] = m_lvl[ix];
    w[10:4] = m_code[ix]; w[15:12] = m_src[ix];
    if (ix == 0) w = w | EXP_CAP;
    return w;
  endfunction

  // ---------------- helpers ----------------
  always @(negedge clk)
    if (ev_rand)
      for (int w = 0; w < FLAT / 32; w++) ev_in[w*32 +: 32] = $urandom;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apb_wr(logic [8:0] a, logic [31:0] d);
    psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(logic [8:0] a, output logic [31:0] got, output logic [31:0] exp);
    psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1;
    got = prdata;
    exp = m_read(a);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic rd_model(string tag, logic [8:0] a);
    logic [31:0] g, e;
    apb_rd(a, g, e);
    check(tag, g, e);
  endtask

  task automatic rd_lit(string tag, logic [8:0] a, logic [31:0] lit);
    logic [31:0] g, e;
    apb_rd(a, g, e);
    check(tag, g, lit);
    check(tag, g, e);
  endtask

  function automatic logic [8:0] adr(int sp, int ix);
    return {2'(sp), 5'(ix), 2'b00};
  endfunction

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] a0, a1, g, e;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd_lit("R1 value0", adr(0, 0), 32'd0);
    rd_lit("R1 max0", adr(2, 0), 32'd0);
    rd_lit("R1 ctrl1", adr(1, 1), 32'd0);
    rd_model("R1 timestamp", adr(3, 0));
    // R7 capability word on counter 0
    rd_lit("R7 capability", adr(1, 0), EXP_CAP);

    // R6 timestamp preset beats increment; one clock passes in the read
    apb_wr(adr(3, 0), 32'h0000_1000);
    rd_lit("R6 ts write", adr(3, 0), 32'h0000_1001);

    // R4 counting and wrap: counter 0, code 0x01, source 0
    apb_wr(adr(1, 0), 32'h0000_0011);
    apb_wr(adr(0, 0), 32'hFFFF_FFFF);
    ev_in[1] = 1'b1; @(negedge clk); ev_in[1] = 1'b0;
    rd_lit("R4 wrap", adr(0, 0), 32'd0);
    ev_in[1] = 1'b1; repeat (3) @(negedge clk); ev_in[1] = 1'b0;
    rd_lit("R4 three cycles", adr(0, 0), 32'd3);
    ev_in[129] = 1'b1; ev_in[2] = 1'b1; repeat (4) @(negedge clk);
    ev_in[129] = 1'b0; ev_in[2] = 1'b0;
    rd_lit("R4 other lines ignored", adr(0, 0), 32'd3);

    // R10 write wins over increment
    ev_in[1] = 1'b1;
    apb_wr(adr(0, 0), 32'h0000_0100);
    rd_lit("R10 write priority", adr(0, 0), 32'h0000_0101);
    ev_in[1] = 1'b0;

    // R5 run-length mode: counter 2, code 0x05, source 3 -> bit 389
    apb_wr(adr(1, 2), 32'h0000_3053);
    rd_lit("R3 fields read back", adr(1, 2), 32'h0000_3053);
    ev_in[389] = 1'b1; repeat (5) @(negedge clk); ev_in[389] = 1'b0;
    repeat (2) @(negedge clk);
    rd_lit("R5 max after run 5", adr(2, 2), 32'd5);
    rd_lit("R5 restart at zero", adr(0, 2), 32'd0);
    ev_in[389] = 1'b1; repeat (3) @(negedge clk); ev_in[389] = 1'b0;
    repeat (2) @(negedge clk);
    rd_lit("R5 shorter run keeps max", adr(2, 2), 32'd5);
    apb_wr(adr(2, 2), 32'd1);
    ev_in[389] = 1'b1; repeat (2) @(negedge clk); ev_in[389] = 1'b0;
    repeat (2) @(negedge clk);
    rd_lit("R5 longer run after preset", adr(2, 2), 32'd2);

    // R9 absent trace group, present external group
    apb_wr(adr(1, 1), 32'h0000_0721);
    apb_wr(adr(1, 3), 32'h0000_1631);
    ev_in = '1; repeat (8) @(negedge clk);
    rd_lit("R9 trace code never counts", adr(0, 1), 32'd0);
    rd_model("R9 external code counts", adr(0, 3));

    // R3 all-zero write stops the counter
    apb_wr(adr(1, 3), 32'd0);
    apb_rd(adr(0, 3), a0, e); check("R3 disabled value", a0, e);
    repeat (4) @(negedge clk);
    apb_rd(adr(0, 3), a1, e); check("R3 value held", a1, a0);
    ev_in = '0;

    // R8 unimplemented slots
    apb_wr(adr(0, 5), 32'h0000_DEAD);
    rd_lit("R8 slot 5 reads zero", adr(0, 5), 32'd0);
    rd_lit("R8 no alias to slot 1", adr(0, 1), 32'd0);
    apb_wr(adr(1, 6), 32'h0000_0011);
    rd_lit("R8 ctrl slot 6 zero", adr(1, 6), 32'd0);
    rd_lit("R8 ctrl slot 2 untouched", adr(1, 2), 32'h0000_3053);
    rd_lit("R8 time region word 1", adr(3, 1), 32'd0);

    // R2 presets of max and value
    apb_wr(adr(2, 3), 32'h0000_55AA);
    rd_lit("R2 max preset", adr(2, 3), 32'h0000_55AA);
    apb_wr(adr(0, 3), 32'h1234_5678);
    rd_lit("R2 value preset", adr(0, 3), 32'h1234_5678);

    // constrained random phase against the model
    ev_rand = 1'b1;
    for (int k = 0; k < 500; k++) begin
      int op = $urandom_range(0, 9);
      int ix = $urandom_range(0, 5);
      int sp = $urandom_range(0, 3);
      case (op)
        0, 1: apb_wr(adr(1, ix), $urandom & 32'h0000_FFF7);
        2:    apb_wr(adr(0, ix), $urandom);
        3:    apb_wr(adr(sp == 1 ? 2 : sp, ix), $urandom_range(0, 8));
        9:    repeat ($urandom_range(1, 6)) @(negedge clk);
        default: begin
          apb_rd(adr(sp, ix), g, e);
          if (sp == 3)        check("R6 random ts", g, e);
          else if (ix >= NCNT) check("R8 random unimpl", g, e);
          else if (sp == 0)   check("R4 random value", g, e);
          else if (sp == 1)   check("R3 random ctrl", g, e);
          else                check("R5 random max", g, e);
        end
      endcase
    end
    ev_rand = 1'b0;

    done = 1;
    finish_run();
  end
endmodule